// File: doc/BRIEF.md
# Interrupt Context Sequencer

This block is the CPU-side state machine that performs the context switch once the interrupt controller has granted an interrupt. It holds the program counter, the status word and a downward-growing stack pointer. When the core signals an accepted interrupt, it writes four bytes onto the stack through a byte-wide memory port, reads a two-byte handler address from a vector table and loads it into the program counter. It then overwrites the interrupt-level field of the status word with the level of the accepted request.

A return command pops the saved bytes in the opposite order, which restores the program counter and the whole status word, including the previous interrupt level. Only these two registers take part in the switch. Any accumulator or scratch registers of the core are left to software. While the core is idle it may load the program counter and status word directly. Memory reads are combinational: read data must be valid in the same cycle as the address.

Top module: `irq_ctx_seq`

## Requirements
- R1: After reset, busy, mem_wr and mem_rd are low, pc and ps are zero, and sp equals SP_INIT.
- R2: On acceptance, the four cycles that follow write, in this order, pc[7:0] to address sp, pc[15:8] to sp-1, ps[7:0] to sp-2 and ps[15:8] to sp-3. sp ends four lower.
- R3: The handler address is read from VEC_BASE - 2*idx (high byte) and the next address up (low byte), and that address is then loaded into pc.
- R4: On entry, ps[1:0] (the level field) becomes the accepted level and ps[15:2], including the enable flag at bit 2, keep their values.
- R5: busy is high for exactly six cycles after the accepting edge and for exactly four cycles after a return command. Every busy cycle performs one memory access.
- R6: take_irq and do_reti are ignored while busy.
- R7: A return reads sp+1, sp+2, sp+3 and sp+4 as ps high, ps low, pc high and pc low. This restores pc and ps and leaves sp four higher.
- R8: When idle, take_irq wins over do_reti in the same cycle. Direct pc/ps writes take effect only while idle and no sequence starts in that cycle.
- R9: mem_wr and mem_rd are never high together, and neither is high while idle.
- R10: Entries nest, and successive returns unwind them in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_irq | input | 1 | Accepted-interrupt pulse |
| irq_idx | input | IDXW | Index of the accepted interrupt |
| irq_lvl | input | 2 | Level of the accepted interrupt |
| do_reti | input | 1 | Return-from-interrupt command |
| pc_we | input | 1 | Direct program counter write (idle only) |
| pc_wdata | input | 16 | Direct program counter value |
| ps_we | input | 1 | Direct status word write (idle only) |
| ps_wdata | input | 16 | Direct status word value |
| mem_addr | output | 16 | Memory byte address |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| busy | output | 1 | Sequence in progress |
| pc | output | 16 | Program counter |
| ps | output | 16 | Status word |
| sp | output | 16 | Stack pointer |

## Verification
On every cycle, the assertions check the exclusive and idle-quiet memory strobes, that each stack write moves sp down by one, and that sp never changes while idle. They also check that a start from idle, and the priority between take_irq and do_reti, produce the right first access. Only the bench scenarios can show the byte order on the stack, the vector fetch and the level overwrite for different indices. The same holds for exact busy lengths, requests dropped mid-sequence and nested entries that unwind in reverse.

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq #(
  parameter int          IDXW     = 3,
  parameter logic [15:0] VEC_BASE = 16'hFFF0,
  parameter logic [15:0] SP_INIT  = 16'h01FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_irq,
  input  logic [IDXW-1:0] irq_idx,
  input  logic [1:0]      irq_lvl,
  input  logic            do_reti,
  input  logic            pc_we,
  input  logic [15:0]     pc_wdata,
  input  logic            ps_we,
  input  logic [15:0]     ps_wdata,
  output logic [15:0]     mem_addr,
  output logic            mem_wr,
  output logic            mem_rd,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic            busy,
  output logic [15:0]     pc,
  output logic [15:0]     ps,
  output logic [15:0]     sp
);
  typedef enum logic [3:0] {
    IDLE, PSH_PCL, PSH_PCH, PSH_PSL, PSH_PSH,
    VEC_HI, VEC_LO, POP_PSH, POP_PSL, POP_PCH, POP_PCL
  } st_t;

  st_t st;
  logic [IDXW-1:0] idx_q;
  logic [1:0]      lvl_q;
  logic [15:0]     vaddr;

  assign vaddr  = VEC_BASE - (16'(idx_q) << 1);
  assign busy   = (st != IDLE);
  assign mem_wr = (st == PSH_PCL) || (st == PSH_PCH) || (st == PSH_PSL) || (st == PSH_PSH);
  assign mem_rd = busy && !mem_wr;

  always_comb begin
    case (st)
      VEC_HI:                            mem_addr = vaddr;
      VEC_LO:                            mem_addr = vaddr + 16'd1;
      POP_PSH, POP_PSL, POP_PCH, POP_PCL: mem_addr = sp + 16'd1;
      default:                           mem_addr = sp;
    endcase
    case (st)
      PSH_PCL: mem_wdata = pc[7:0];
      PSH_PCH: mem_wdata = pc[15:8];
      PSH_PSL: mem_wdata = ps[7:0];
      PSH_PSH: mem_wdata = ps[15:8];
      default: mem_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      pc    <= '0;
      ps    <= '0;
      sp    <= SP_INIT;
      idx_q <= '0;
      lvl_q <= '0;
    end else begin
      case (st)
        IDLE: begin
          if (take_irq) begin
            st    <= PSH_PCL;
            idx_q <= irq_idx;
            lvl_q <= irq_lvl;
          end else if (do_reti) begin
            st <= POP_PSH;
          end else begin
            if (pc_we) pc <= pc_wdata;
            if (ps_we) ps <= ps_wdata;
          end
        end
        PSH_PCL: begin sp <= sp - 16'd1; st <= PSH_PCH; end
        PSH_PCH: begin sp <= sp - 16'd1; st <= PSH_PSL; end
        PSH_PSL: begin sp <= sp - 16'd1; st <= PSH_PSH; end
        PSH_PSH: begin sp <= sp - 16'd1; st <= VEC_HI;  end
        VEC_HI:  begin pc[15:8] <= mem_rdata; st <= VEC_LO; end
        VEC_LO: begin
          pc[7:0] <= mem_rdata;
          ps[1:0] <= lvl_q;
          st      <= IDLE;
        end
        POP_PSH: begin sp <= sp + 16'd1; ps[15:8] <= mem_rdata; st <= POP_PSL; end
        POP_PSL: begin sp <= sp + 16'd1; ps[7:0]  <= mem_rdata; st <= POP_PCH; end
        POP_PCH: begin sp <= sp + 16'd1; pc[15:8] <= mem_rdata; st <= POP_PCL; end
        POP_PCL: begin sp <= sp + 16'd1; pc[7:0]  <= mem_rdata; st <= IDLE;    end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module irq_ctx_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        take_irq,
  input logic        do_reti,
  input logic        busy,
  input logic        mem_wr,
  input logic        mem_rd,
  input logic [15:0] mem_addr,
  input logic [15:0] sp
);
  assert_excl_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_wr && !mem_rd));
  assert_busy_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_wr || mem_rd));
  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_wr) |=> (sp == $past(sp) - 16'd1));
  assert_idle_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(sp));
  assert_entry_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && take_irq) |=> (busy && mem_wr && mem_addr == $past(sp)));
  assert_return_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && do_reti && !take_irq) |=> (busy && mem_rd && mem_addr == $past(sp) + 16'd1));
endmodule

bind irq_ctx_seq irq_ctx_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .take_irq(take_irq), .do_reti(do_reti),
  .busy(busy), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .sp(sp)
);

// File: tb/sim_irq_ctx_seq.sv
module sim_irq_ctx_seq;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] SP0        = 16'h0180;
  localparam logic [15:0] VBASE      = 16'hFFF0;

  logic        clk = 0, rst_n = 0;
  logic        take_irq = 0, do_reti = 0, pc_we = 0, ps_we = 0;
  logic [2:0]  irq_idx = 0;
  logic [1:0]  irq_lvl = 0;
  logic [15:0] pc_wdata = 0, ps_wdata = 0;
  logic [15:0] mem_addr, pc, ps, sp;
  logic        mem_wr, mem_rd, busy;
  logic [7:0]  mem_wdata, mem_rdata;

  int errs = 0, checks = 0;
  logic [7:0]  mem [256];
  logic [15:0] wa [64];
  logic [7:0]  wd [64];
  int wn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctx_seq #(.IDXW(3), .VEC_BASE(VBASE), .SP_INIT(SP0)) u0 (
    .clk(clk), .rst_n(rst_n), .take_irq(take_irq), .irq_idx(irq_idx), .irq_lvl(irq_lvl),
    .do_reti(do_reti), .pc_we(pc_we), .pc_wdata(pc_wdata), .ps_we(ps_we), .ps_wdata(ps_wdata),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .pc(pc), .ps(ps), .sp(sp));

  function automatic logic [15:0] vec_of(int i);
    return 16'h4000 + 16'(i) * 16'h0203 + 16'h0011;
  endfunction

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        logic [15:0] a, v;
        a = VBASE - 16'(2 * i);
        v = vec_of(i);
        mem[a[7:0]]        <= v[15:8];
        mem[a[7:0] + 8'd1] <= v[7:0];
      end
    end else if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      if (wn < 64) begin
        wa[wn] <= mem_addr;
        wd[wn] <= mem_wdata;
      end
      wn <= wn + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_regs(logic [15:0] p, logic [15:0] s);
    @(negedge clk);
    pc_we = 1; pc_wdata = p; ps_we = 1; ps_wdata = s;
    @(negedge clk);
    pc_we = 0; ps_we = 0;
  endtask

  task automatic accept(logic [2:0] i, logic [1:0] l, output int bc);
    @(negedge clk);
    take_irq = 1; irq_idx = i; irq_lvl = l;
    @(negedge clk);
    take_irq = 0;
    bc = 0;
    while (busy) begin bc++; @(negedge clk); end
  endtask

  task automatic reti(output int bc);
    @(negedge clk);
    do_reti = 1;
    @(negedge clk);
    do_reti = 0;
    bc = 0;
    while (busy) begin bc++; @(negedge clk); end
  endtask

  localparam int NROWS = 6;
  localparam logic [36:0] ROWS [NROWS] = '{
    {3'd0, 2'd1, 16'h1234, 16'h0004},
    {3'd7, 2'd2, 16'hABCD, 16'h8007},
    {3'd3, 2'd1, 16'h00FF, 16'hFF00},
    {3'd5, 2'd3, 16'hFF00, 16'h0003},
    {3'd2, 2'd2, 16'h8001, 16'h7FFB},
    {3'd6, 2'd0, 16'h0000, 16'hFFFF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R5 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int bc, ws;
    logic [15:0] s0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {mem_wr, mem_rd}, 0);
    chk("R1 pc", pc, 0);
    chk("R1 ps", ps, 0);
    chk("R1 sp", sp, SP0);
    rst_n = 1;

    for (int r = 0; r < NROWS; r++) begin
      logic [2:0]  ix;
      logic [1:0]  lv;
      logic [15:0] p0, q0;
      {ix, lv, p0, q0} = ROWS[r];
      set_regs(p0, q0);
      chk("R8 idle pc write", pc, p0);
      s0 = sp; ws = wn;
      accept(ix, lv, bc);
      chk("R5 entry busy cycles", bc, 6);
      chk("R3 vector pc", pc, vec_of(int'(ix)));
      chk("R4 level field", ps, {q0[15:2], lv});
      chk("R2 sp after entry", sp, s0 - 16'd4);
      chk("R2 write count", wn - ws, 4);
      chk("R2 pc low", {wa[ws],   wd[ws]},   {s0,          p0[7:0]});
      chk("R2 pc high", {wa[ws+1], wd[ws+1]}, {s0 - 16'd1,  p0[15:8]});
      chk("R2 ps low", {wa[ws+2], wd[ws+2]}, {s0 - 16'd2,  q0[7:0]});
      chk("R2 ps high", {wa[ws+3], wd[ws+3]}, {s0 - 16'd3, q0[15:8]});
      reti(bc);
      chk("R5 return busy cycles", bc, 4);
      chk("R7 pc restored", pc, p0);
      chk("R7 ps restored", ps, q0);
      chk("R7 sp restored", sp, s0);
    end

    // R6: requests and direct writes during a busy entry are dropped
    set_regs(16'h2222, 16'h0100);
    s0 = sp;
    @(negedge clk);
    take_irq = 1; irq_idx = 3'd1; irq_lvl = 2'd1;
    @(negedge clk);
    irq_idx = 3'd4; irq_lvl = 2'd2; do_reti = 1; pc_we = 1; pc_wdata = 16'h9999;
    ps_we = 1; ps_wdata = 16'hEEEE;
    repeat (3) @(negedge clk);
    take_irq = 0; do_reti = 0; pc_we = 0; ps_we = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R6 no second entry", busy, 0);
    chk("R6 pc from first vector", pc, vec_of(1));
    chk("R6 ps level first", ps, 16'h0101);
    chk("R6 sp one frame", sp, s0 - 16'd4);
    reti(bc);
    chk("R6 unwind pc", pc, 16'h2222);
    chk("R6 unwind sp", sp, s0);

    // R8: accept wins over return in the same idle cycle, and the direct write is dropped
    set_regs(16'h3333, 16'h0002);
    s0 = sp;
    @(negedge clk);
    take_irq = 1; do_reti = 1; irq_idx = 3'd2; irq_lvl = 2'd3;
    pc_we = 1; pc_wdata = 16'h7777;
    @(negedge clk);
    take_irq = 0; do_reti = 0; pc_we = 0;
    chk("R8 first access is write", {mem_wr, mem_rd}, 2'b10);
    while (busy) @(negedge clk);
    chk("R8 entry taken", pc, vec_of(2));
    chk("R8 sp lowered", sp, s0 - 16'd4);
    chk("R9 idle strobes", {mem_wr, mem_rd}, 0);
    reti(bc);
    chk("R8 start write dropped", pc, 16'h3333);

    // R10: nested entries unwind in reverse
    set_regs(16'h5150, 16'h0005);
    s0 = sp;
    accept(3'd4, 2'd2, bc);
    accept(3'd0, 2'd1, bc);
    chk("R10 inner pc", pc, vec_of(0));
    chk("R10 inner sp", sp, s0 - 16'd8);
    chk("R10 inner ps", ps, 16'h0005);
    reti(bc);
    chk("R10 outer pc", pc, vec_of(4));
    chk("R10 outer ps", ps, 16'h0006);
    reti(bc);
    chk("R10 base pc", pc, 16'h5150);
    chk("R10 base ps", ps, 16'h0005);
    chk("R10 base sp", sp, s0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule